// File: doc/BRIEF.md
# Indexed Configuration Port with Unlock Key

This block is the configuration front end of a legacy I/O-bus peripheral controller. Software reaches it through two byte-wide I/O ports. It writes a register index to the index port, then reads or writes that register through the data port. The configuration space stays shut until a fixed four-byte key has been written in sequence to the index port. An exit command then shuts it again.

While the space is open, the block gives access to three global registers and to one banked register group:

- a logical device selector;
- a read-only chip identifier;
- a read-only revision;
- a banked group that belongs to the general-purpose I/O logical device. This group holds a 16-bit I/O base address.

The current selector value, the open/closed state and the I/O base address are driven out to sibling blocks. Bus reads that hit either port return their byte one clock after the read strobe, marked by a valid pulse.

Top module: `sio_cfg_port`

## Requirements
- R1: The index port answers at I/O address 0x002E and the data port at 0x002F (parameters). A read strobe that hits either port gives `io_rvalid` high with the byte on `io_rdata` in the next cycle. A read of any other address gives no `io_rvalid`. While the space is open, an index-port read returns the current index.
- R2: The space opens only after the bytes 0x87, 0x01, 0x55, 0x55 have been written to the index port in consecutive index-port writes. `cfg_open` goes high in the cycle after the last key byte.
- R3: An index-port write that does not match the expected key byte restarts matching. That same byte is then tested as the first key byte, so 0x87, 0x87, 0x01, 0x55, 0x55 opens the space.
- R4: While the space is open, writing index 0x02 and then data byte 0x02 closes it. Any other data value written at index 0x02 leaves the space open.
- R5: Index 0x07 is a read/write logical device number register, and its value drives `ldn_sel`.
- R6: While the space is closed, reads of either port return 0xFF, and data-port writes change no register.
- R7: Indices 0x20 and 0x21 return the high and low bytes of the chip identifier (default 0x8728). Writes to them have no effect.
- R8: Index 0x22 returns the 4-bit revision (default 3) in bits 3:0, with bits 7:4 read as zero.
- R9: When `ldn_sel` equals 0x07, indices 0x62 (high byte) and 0x63 (low byte) read and write the I/O base address that drives `gpio_base`. With any other device selected, those indices read 0x00 and writes to them are ignored.
- R10: A read of an unimplemented index, including 0x02, returns 0x00.
- R11: Reset closes the space, clears the logical device number and the index to 0, and loads `gpio_base` with 0x0A00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O bus address |
| io_wdata | input | 8 | I/O write byte |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read byte, valid with io_rvalid |
| io_rvalid | output | 1 | Read response pulse, one cycle after io_rd |
| cfg_open | output | 1 | Configuration space is open |
| ldn_sel | output | 8 | Selected logical device number |
| gpio_base | output | 16 | I/O base address of the general-purpose I/O device |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high in the same cycle, and that every access lasts one strobe cycle. The exit and key properties count each strobe as exactly one bus operation, so these assumptions matter. The bench drives each access as a single-cycle pulse from its own task, one access at a time, and leaves idle cycles between accesses. It also deliberately targets a foreign address to show that such a read goes unanswered.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   localparam int KEY_LEN = 4;
   // first key byte is the most significant element
   localparam logic [KEY_LEN-1:0][7:0] UNLOCK_KEY = {8'h87, 8'h01, 8'h55, 8'h55};

   localparam logic [7:0] IDX_EXIT  = 8'h02;
   localparam logic [7:0] IDX_LDN   = 8'h07;
   localparam logic [7:0] IDX_ID_HI = 8'h20;
   localparam logic [7:0] IDX_ID_LO = 8'h21;
   localparam logic [7:0] IDX_REV   = 8'h22;
   localparam logic [7:0] EXIT_CMD  = 8'h02;
   localparam logic [7:0] CLOSED_RD = 8'hFF;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
   import sio_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       idx_wr,
   input  logic [7:0] wbyte,
   output logic       key_done
);
   localparam int CW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(KEY_LEN - 1);

   logic [CW-1:0] pos_q;
   logic [7:0]    want;
   logic          hit, first_hit;

   always_comb begin
      want      = UNLOCK_KEY[KEY_LEN-1-int'(pos_q)];
      hit       = (wbyte == want);
      first_hit = (wbyte == UNLOCK_KEY[KEY_LEN-1]);
      key_done  = idx_wr && hit && (pos_q == LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_q <= '0;
      else if (clr)
         pos_q <= '0;
      else if (idx_wr) begin
         if (hit)
            pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
         else
            pos_q <= first_hit ? CW'(1) : '0;
      end
   end
endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file
   import sio_cfg_pkg::*;
#(
   parameter logic [15:0] CHIP_ID    = 16'h8728,
   parameter logic [3:0]  CHIP_REV   = 4'h3,
   parameter logic [7:0]  DEV_LDN    = 8'h07,
   parameter logic [7:0]  BASE_IDX   = 8'h62,
   parameter int          BASE_BYTES = 2,
   parameter logic [8*BASE_BYTES-1:0] BASE_RESET = 16'h0A00
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    idx_we,
   input  logic                    dat_we,
   input  logic [7:0]              wbyte,
   output logic [7:0]              cur_idx,
   output logic [7:0]              rd_byte,
   output logic [7:0]              ldn_out,
   output logic [8*BASE_BYTES-1:0] base_out
);
   localparam int BW = 8 * BASE_BYTES;

   if (BASE_BYTES < 1 || BASE_BYTES > 4) begin : g_bad_bytes
      $error("BASE_BYTES must be 1..4");
   end
   if (int'(BASE_IDX) < 8'h30 || int'(BASE_IDX) + BASE_BYTES > 256) begin : g_bad_idx
      $error("BASE_IDX overlaps global registers or wraps");
   end

   logic [7:0] idx_q, ldn_q;
   logic       dev_sel;
   logic [BASE_BYTES-1:0] base_hit;
   logic [7:0] base_val [BASE_BYTES];

   assign dev_sel = (ldn_q == DEV_LDN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         ldn_q <= '0;
      end else begin
         if (idx_we)
            idx_q <= wbyte;
         if (dat_we && idx_q == IDX_LDN)
            ldn_q <= wbyte;
      end
   end

   for (genvar b = 0; b < BASE_BYTES; b++) begin : g_base
      localparam int SH = 8 * (BASE_BYTES - 1 - b);
      localparam logic [7:0] MY_IDX = BASE_IDX + 8'(b);
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= BASE_RESET[SH +: 8];
         else if (dat_we && dev_sel && idx_q == MY_IDX)
            q <= wbyte;
      end
      assign base_out[SH +: 8] = q;
      assign base_hit[b]       = dev_sel && (idx_q == MY_IDX);
      assign base_val[b]       = q;
   end

   always_comb begin
      rd_byte = 8'h00;
      unique case (idx_q)
         IDX_LDN:   rd_byte = ldn_q;
         IDX_ID_HI: rd_byte = CHIP_ID[15:8];
         IDX_ID_LO: rd_byte = CHIP_ID[7:0];
         IDX_REV:   rd_byte = {4'h0, CHIP_REV};
         default: begin
            for (int b = 0; b < BASE_BYTES; b++)
               if (base_hit[b]) rd_byte = base_val[b];
         end
      endcase
   end

   assign cur_idx = idx_q;
   assign ldn_out = ldn_q;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import sio_cfg_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter logic [15:0] INDEX_ADDR = 16'h002E,
   parameter logic [15:0] CHIP_ID    = 16'h8728,
   parameter logic [3:0]  CHIP_REV   = 4'h3,
   parameter logic [7:0]  GPIO_LDN   = 8'h07,
   parameter logic [7:0]  BASE_IDX   = 8'h62,
   parameter logic [15:0] BASE_RESET = 16'h0A00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [7:0]        io_wdata,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic [7:0]        io_rdata,
   output logic              io_rvalid,
   output logic              cfg_open,
   output logic [7:0]        ldn_sel,
   output logic [15:0]       gpio_base
);
   localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(INDEX_ADDR);
   localparam logic [ADDR_W-1:0] DAT_PORT = ADDR_W'(INDEX_ADDR) + 1'b1;

   if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W must be 8..16");
   end
   if (INDEX_ADDR[0] != 1'b0) begin : g_bad_port
      $error("INDEX_ADDR must be even");
   end

   logic hit_idx, hit_dat, key_done, exit_hit, open_q;
   logic [7:0] cur_idx, rd_byte;

   assign hit_idx  = (io_addr == IDX_PORT);
   assign hit_dat  = (io_addr == DAT_PORT);
   assign exit_hit = open_q && io_wr && hit_dat &&
                     (cur_idx == IDX_EXIT) && (io_wdata == EXIT_CMD);

   sio_key_fsm u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (open_q),
      .idx_wr   (io_wr && hit_idx && !open_q),
      .wbyte    (io_wdata),
      .key_done (key_done)
   );

   sio_reg_file #(
      .CHIP_ID    (CHIP_ID),
      .CHIP_REV   (CHIP_REV),
      .DEV_LDN    (GPIO_LDN),
      .BASE_IDX   (BASE_IDX),
      .BASE_BYTES (2),
      .BASE_RESET (BASE_RESET)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_we   (io_wr && hit_idx && open_q),
      .dat_we   (io_wr && hit_dat && open_q),
      .wbyte    (io_wdata),
      .cur_idx  (cur_idx),
      .rd_byte  (rd_byte),
      .ldn_out  (ldn_sel),
      .base_out (gpio_base)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         open_q <= 1'b0;
      else if (exit_hit)
         open_q <= 1'b0;
      else if (key_done)
         open_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_rvalid <= 1'b0;
         io_rdata  <= 8'h00;
      end else begin
         io_rvalid <= io_rd && (hit_idx || hit_dat);
         if (io_rd) begin
            if (!open_q)      io_rdata <= CLOSED_RD;
            else if (hit_idx) io_rdata <= cur_idx;
            else              io_rdata <= rd_byte;
         end
      end
   end

   assign cfg_open = open_q;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
   parameter int          ADDR_W     = 16,
   parameter logic [15:0] INDEX_ADDR = 16'h002E
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic [7:0]        io_wdata,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_rdata,
   input logic              io_rvalid,
   input logic              cfg_open,
   input logic [7:0]        ldn_sel,
   input logic [15:0]       gpio_base,
   input logic [7:0]        cur_idx
);
   localparam logic [ADDR_W-1:0] P_IDX = ADDR_W'(INDEX_ADDR);
   localparam logic [ADDR_W-1:0] P_DAT = ADDR_W'(INDEX_ADDR) + 1'b1;

   // R2: opening is always preceded by the final key byte on the index port
   a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(io_wr && io_addr == P_IDX && io_wdata == 8'h55));

   // R4: exit command closes the space
   a_r4_exit_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && io_wr && io_addr == P_DAT && cur_idx == 8'h02 && io_wdata == 8'h02)
      |=> !cfg_open);

   // R6: closed reads return all ones
   a_r6_closed_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && io_rd && (io_addr == P_IDX || io_addr == P_DAT))
      |=> (io_rvalid && io_rdata == 8'hFF));

   // R6: closed writes leave exported registers alone
   a_r6_closed_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && io_wr) |=> ($stable(ldn_sel) && $stable(gpio_base)));

   // R1: a response appears exactly one cycle after a port read
   a_r1_resp_timing: assert property (@(posedge clk) disable iff (!rst_n)
      io_rvalid |-> $past(io_rd && (io_addr == P_IDX || io_addr == P_DAT)));

   // R1: a read of the index port while open returns the index
   a_r1_index_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && io_rd && io_addr == P_IDX) |=> (io_rdata == $past(cur_idx)));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
   .ADDR_W     (ADDR_W),
   .INDEX_ADDR (INDEX_ADDR)
) u_chk (.*);

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
   localparam logic [15:0] PI = 16'h002E;
   localparam logic [15:0] PD = 16'h002F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_rdata;
   logic        io_rvalid;
   logic        cfg_open;
   logic [7:0]  ldn_sel;
   logic [15:0] gpio_base;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   sio_cfg_port u0 (.*);

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      io_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic creg_rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
      wr(PI, idx);
      rd(PD, exp, tag);
   endtask

   task automatic creg_wr(input logic [7:0] idx, input logic [7:0] d);
      wr(PI, idx);
      wr(PD, d);
   endtask

   task automatic unlock();
      wr(PI, 8'h87); wr(PI, 8'h01); wr(PI, 8'h55); wr(PI, 8'h55);
   endtask

   // monitor: compares each response with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && io_rvalid) begin
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R1 unexpected response actual=%h expected=none", io_rdata);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (io_rdata !== e) begin
               failures++;
               $display("FAIL %s actual=%h expected=%h", t, io_rdata, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(16'(cfg_open), 16'h0, "R11 closed after reset");
      chk(16'(ldn_sel), 16'h0, "R11 ldn after reset");
      chk(gpio_base, 16'h0A00, "R11 base after reset");

      rd(PD, 8'hFF, "R6 closed data read");
      rd(PI, 8'hFF, "R6 closed index read");
      rd(16'h0080, 8'h00, "R1 foreign read unused");
      void'(exp_q.pop_back()); void'(tag_q.pop_back());
      chk(16'(exp_q.size()), 16'h0, "R1 foreign read gave no response");

      wr(PD, 8'h33);
      chk(16'(ldn_sel), 16'h0, "R6 closed data write ignored");

      // broken key does not open
      wr(PI, 8'h87); wr(PI, 8'h01); wr(PI, 8'h55); wr(PI, 8'hAA);
      chk(16'(cfg_open), 16'h0, "R3 broken key stays closed");
      // breaking byte re-evaluated as first key byte
      wr(PI, 8'h87); wr(PI, 8'h87); wr(PI, 8'h01); wr(PI, 8'h55); wr(PI, 8'h55);
      chk(16'(cfg_open), 16'h1, "R3 restart on breaking byte opens");
      rd(PI, 8'h00, "R11 index cleared by reset");

      creg_rd(8'h07, 8'h00, "R6 ldn unchanged by closed write");

      // exit path
      creg_wr(8'h02, 8'h05);
      chk(16'(cfg_open), 16'h1, "R4 wrong exit value stays open");
      wr(PD, 8'h02);
      chk(16'(cfg_open), 16'h0, "R4 exit closes");
      rd(PD, 8'hFF, "R6 read after exit");

      unlock();
      chk(16'(cfg_open), 16'h1, "R2 key opens");

      creg_rd(8'h20, 8'h87, "R7 id high");
      creg_rd(8'h21, 8'h28, "R7 id low");
      creg_wr(8'h20, 8'h11);
      creg_rd(8'h20, 8'h87, "R7 id write ignored");
      creg_rd(8'h22, 8'h03, "R8 revision");

      creg_wr(8'h07, 8'h05);
      chk(16'(ldn_sel), 16'h5, "R5 ldn output");
      creg_rd(8'h07, 8'h05, "R5 ldn readback");
      creg_rd(8'h62, 8'h00, "R9 base hidden when other ldn");
      creg_wr(8'h62, 8'h12);
      chk(gpio_base, 16'h0A00, "R9 base write ignored other ldn");

      creg_wr(8'h07, 8'h07);
      creg_rd(8'h62, 8'h0A, "R9 base high default");
      creg_wr(8'h62, 8'h12);
      creg_wr(8'h63, 8'h34);
      chk(gpio_base, 16'h1234, "R9 base output");
      creg_rd(8'h63, 8'h34, "R9 base low readback");

      creg_rd(8'h55, 8'h00, "R10 unimplemented index");
      creg_rd(8'h02, 8'h00, "R10 exit index reads zero");
      wr(PI, 8'h21);
      rd(PI, 8'h21, "R1 index port readback");

      creg_wr(8'h02, 8'h02);
      chk(16'(cfg_open), 16'h0, "R4 second exit closes");
      chk(gpio_base, 16'h1234, "R6 base kept while closed");
      wr(PD, 8'h99);
      chk(gpio_base, 16'h1234, "R6 closed write no base change");

      repeat (4) @(negedge clk);
      chk(16'(exp_q.size()), 16'h0, "R1 all responses received");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule